// File: doc/BRIEF.md
# Divider configuration loader

This block holds the divider settings of a clock synthesizer: the reference pre-divider code, the feedback divider (integer and fractional parts), the two output divider codes, a fractional-mode select and a two-bit test select. Two programming paths share one set of active registers. The parallel path copies the integer feedback value and both output divider codes from static buses. The serial path shifts a 31-bit frame in from a slow serial clock and then moves that frame into the settings.

Parallel mode is transparent while its load strobe is low and holds its values once the strobe goes high. Serial mode shifts while the strobe is high. A rising transfer line copies the frame into the settings. While the line stays high the settings follow the shift register bit by bit, and its falling edge freezes them. The setting loaded last wins. Every control input is brought into the system clock domain through a synchronizer before any edge is detected.

Top module: `divcfg_loader`

## Requirements
- R1: While the synchronized parallel strobe is low, the integer feedback and both output divider outputs follow the parallel buses, one clock after the synchronized values.
- R2: After the parallel strobe goes high, later changes on the parallel buses do not change any output.
- R3: The parallel path never changes the fractional feedback, pre-divider, mode-select or test-select settings.
- R4: The shift register advances by one bit on each synchronized serial-clock rising edge only while the parallel strobe is high. Serial clocks and transfer pulses given while the strobe is low change nothing.
- R5: A rising edge on the transfer line copies the frame into the settings. The first bit sent lands in bit 30, and the layout from MSB to LSB is test select [30:29], output B code [28:26], output A code [25:23], pre-divider code [22:20], mode select [19:18], integer feedback [17:12], fractional feedback [11:0].
- R6: After the transfer line falls, further shifting leaves every setting unchanged.
- R7: While the transfer line is high, each serial-clock rising edge also updates the settings with the shifted frame.
- R8: The test output is low in parallel-transparent mode. With test select 01 it carries shift-register bit 30. With the reserved codes 10 and 11, and with code 00, it is low.
- R9: While reset is asserted the settings become pre-divider 000, both output codes 011, mode select 00, test select 00, fractional 0, and integer feedback equal to the parallel integer bus.
- R10: A parallel load after a serial load replaces only the integer and output divider fields and keeps the serial fractional value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| par_load_n | input | 1 | Parallel strobe: low is transparent, high holds |
| par_m | input | 6 | Parallel integer feedback value |
| par_na | input | 3 | Parallel output A divider code |
| par_nb | input | 3 | Parallel output B divider code |
| ser_clk | input | 1 | Serial shift clock, sampled |
| ser_data | input | 1 | Serial data, sampled |
| ser_load | input | 1 | Serial transfer line |
| pre_div | output | 3 | Active pre-divider code |
| m_int | output | 6 | Active integer feedback value |
| m_frac | output | 12 | Active fractional feedback value |
| n_a | output | 3 | Active output A divider code |
| n_b | output | 3 | Active output B divider code |
| frac_mode | output | 2 | Active mode select |
| test_out | output | 1 | Test output selected by the test-select bits |

## Verification
The assertions assume that every control line is slow against the system clock and stays in each level for several clocks, so that one level change gives exactly one synchronized edge. They also assume that the data and parallel buses are steady for a few clocks before the edge that samples them. The stimulus holds each serial level and each strobe level for at least four system clocks and changes the buses only in settled phases. Because of this, the synchronizer latency never splits one stimulus step across two different outcomes.

// File: rtl/divcfg_pkg.sv
`timescale 1ns/1ps
package divcfg_pkg;
   parameter int unsigned DIV_W  = 3;
   parameter int unsigned MI_W   = 6;
   parameter int unsigned MF_W   = 12;
   parameter int unsigned DS_W   = 2;
   parameter int unsigned TS_W   = 2;
   localparam int unsigned FRAME_W = TS_W + 3 * DIV_W + DS_W + MI_W + MF_W;

   localparam logic [DIV_W-1:0] OUT_DIV_DEFAULT = DIV_W'(3);
   localparam logic [TS_W-1:0]  TEST_FROM_SHIFT = TS_W'(1);

   // field order equals frame order, MSB first
   typedef struct packed {
      logic [TS_W-1:0]  tsel;
      logic [DIV_W-1:0] nb;
      logic [DIV_W-1:0] na;
      logic [DIV_W-1:0] pdiv;
      logic [DS_W-1:0]  dsel;
      logic [MI_W-1:0]  mint;
      logic [MF_W-1:0]  mfrac;
   } cfg_t;
endpackage

// File: rtl/divcfg_sync.sv
`timescale 1ns/1ps
module divcfg_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("divcfg_sync needs at least two stages");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/divcfg_shift.sv
`timescale 1ns/1ps
module divcfg_shift
   import divcfg_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               shift_en,
   input  logic               sclk,
   input  logic               sdata,
   output logic [FRAME_W-1:0] sr_q,
   output logic [FRAME_W-1:0] sr_next
);
   logic sclk_prev;
   logic step;

   assign step    = shift_en && sclk && !sclk_prev;
   assign sr_next = step ? {sr_q[FRAME_W-2:0], sdata} : sr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sclk_prev <= 1'b0;
         sr_q      <= '0;
      end else begin
         sclk_prev <= sclk;
         sr_q      <= sr_next;
      end
   end

   // R4: without a qualified serial edge the register keeps its contents
   assert_shift_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(sr_q));
endmodule

// File: rtl/divcfg_active.sv
`timescale 1ns/1ps
module divcfg_active
   import divcfg_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               par_mode,
   input  logic               ser_track,
   input  logic [MI_W-1:0]    par_m,
   input  logic [DIV_W-1:0]   par_na,
   input  logic [DIV_W-1:0]   par_nb,
   input  logic [FRAME_W-1:0] sr_next,
   output cfg_t               cfg_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q      <= '0;
         cfg_q.na   <= OUT_DIV_DEFAULT;
         cfg_q.nb   <= OUT_DIV_DEFAULT;
         cfg_q.mint <= par_m;
      end else if (par_mode) begin
         cfg_q.mint <= par_m;
         cfg_q.na   <= par_na;
         cfg_q.nb   <= par_nb;
      end else if (ser_track) begin
         cfg_q <= cfg_t'(sr_next);
      end
   end

   assert_par_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
      par_mode |=> (cfg_q.mint == $past(par_m) && cfg_q.na == $past(par_na)
                    && cfg_q.nb == $past(par_nb)));

   assert_par_no_frac_R3: assert property (@(posedge clk) disable iff (!rst_n)
      par_mode |=> ($stable(cfg_q.mfrac) && $stable(cfg_q.pdiv)
                    && $stable(cfg_q.dsel) && $stable(cfg_q.tsel)));

   // R2 / R6: no active load path means the settings are frozen
   assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!par_mode && !ser_track) |=> $stable(cfg_q));
endmodule

// File: rtl/divcfg_loader.sv
`timescale 1ns/1ps
module divcfg_loader
   import divcfg_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             par_load_n,
   input  logic [MI_W-1:0]  par_m,
   input  logic [DIV_W-1:0] par_na,
   input  logic [DIV_W-1:0] par_nb,
   input  logic             ser_clk,
   input  logic             ser_data,
   input  logic             ser_load,
   output logic [DIV_W-1:0] pre_div,
   output logic [MI_W-1:0]  m_int,
   output logic [MF_W-1:0]  m_frac,
   output logic [DIV_W-1:0] n_a,
   output logic [DIV_W-1:0] n_b,
   output logic [DS_W-1:0]  frac_mode,
   output logic             test_out
);
   localparam int unsigned NUM_CTL = 4;
   // index: 0 data, 1 serial clock, 2 transfer line, 3 parallel strobe
   localparam logic [NUM_CTL-1:0] CTL_RST = 4'b1000;

   logic [NUM_CTL-1:0] ctl_raw, ctl_s;
   assign ctl_raw = {par_load_n, ser_load, ser_clk, ser_data};

   for (genvar gi = 0; gi < NUM_CTL; gi++) begin : g_sync
      divcfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(CTL_RST[gi])) u_sync (
         .clk(clk), .rst_n(rst_n), .d(ctl_raw[gi]), .q(ctl_s[gi]));
   end

   logic strobe_s, load_s;
   assign strobe_s = ctl_s[3];
   assign load_s   = ctl_s[2];

   logic [FRAME_W-1:0] sr_q, sr_next;
   cfg_t               cfg;

   divcfg_shift u_shift (
      .clk(clk), .rst_n(rst_n), .shift_en(strobe_s),
      .sclk(ctl_s[1]), .sdata(ctl_s[0]), .sr_q(sr_q), .sr_next(sr_next));

   divcfg_active u_active (
      .clk(clk), .rst_n(rst_n), .par_mode(!strobe_s),
      .ser_track(strobe_s && load_s), .par_m(par_m), .par_na(par_na),
      .par_nb(par_nb), .sr_next(sr_next), .cfg_q(cfg));

   assign pre_div   = cfg.pdiv;
   assign m_int     = cfg.mint;
   assign m_frac    = cfg.mfrac;
   assign n_a       = cfg.na;
   assign n_b       = cfg.nb;
   assign frac_mode = cfg.dsel;
   assign test_out  = strobe_s && (cfg.tsel == TEST_FROM_SHIFT) && sr_q[FRAME_W-1];

   assert_track_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_s && load_s) |=> (cfg == cfg_t'(sr_q)));

   assert_test_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.tsel != TEST_FROM_SHIFT) |-> !test_out);
endmodule

// File: tb/test_divcfg_loader.sv
`timescale 1ns/1ps
module test_divcfg_loader;
   import divcfg_pkg::*;

   logic clk = 1'b0, rst_n = 1'b0;
   logic par_load_n = 1'b1, ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0;
   logic [5:0] par_m = 6'd21;
   logic [2:0] par_na = 3'd1, par_nb = 3'd5;
   logic [2:0] pre_div, n_a, n_b;
   logic [5:0] m_int;
   logic [11:0] m_frac;
   logic [1:0] frac_mode;
   logic test_out;

   int errors = 0, checks = 0;
   bit done = 1'b0;
   logic [FRAME_W-1:0] e_sr = '0;
   cfg_t e_cfg;

   always #4 clk = ~clk;

   divcfg_loader i_divcfg_loader (
      .clk(clk), .rst_n(rst_n), .par_load_n(par_load_n), .par_m(par_m),
      .par_na(par_na), .par_nb(par_nb), .ser_clk(ser_clk), .ser_data(ser_data),
      .ser_load(ser_load), .pre_div(pre_div), .m_int(m_int), .m_frac(m_frac),
      .n_a(n_a), .n_b(n_b), .frac_mode(frac_mode), .test_out(test_out));

   task automatic settle();
      repeat (6) @(negedge clk);
   endtask

   task automatic check(input string tag);
      logic [29:0] act, exp;
      logic e_test;
      e_test = par_load_n && (e_cfg.tsel == 2'b01) && e_sr[FRAME_W-1];
      act = {n_b, n_a, pre_div, frac_mode, m_int, m_frac, test_out};
      exp = {e_cfg.nb, e_cfg.na, e_cfg.pdiv, e_cfg.dsel, e_cfg.mint, e_cfg.mfrac, e_test};
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic ser_bit(input logic b, input string tag, input bit chk);
      ser_data = b;
      repeat (4) @(negedge clk);
      ser_clk = 1'b1;
      repeat (4) @(negedge clk);
      ser_clk = 1'b0;
      repeat (4) @(negedge clk);
      if (par_load_n) begin
         e_sr = {e_sr[FRAME_W-2:0], b};
         if (ser_load) e_cfg = cfg_t'(e_sr);
      end
      if (chk) check(tag);
   endtask

   task automatic load_pulse(input string tag);
      ser_load = 1'b1;
      settle();
      if (par_load_n) e_cfg = cfg_t'(e_sr);
      check(tag);
      ser_load = 1'b0;
      settle();
   endtask

   task automatic send_frame(input cfg_t f);
      logic [FRAME_W-1:0] v;
      v = f;
      for (int i = FRAME_W - 1; i >= 0; i--) ser_bit(v[i], "R4", 1'b0);
   endtask

   task automatic par_op(input logic [5:0] m, input logic [2:0] na, input logic [2:0] nb);
      par_m = m; par_na = na; par_nb = nb;
      par_load_n = 1'b0;
      settle();
      e_cfg.mint = m; e_cfg.na = na; e_cfg.nb = nb;
      check("R1 R3 R10");
      par_load_n = 1'b1;
      settle();
      par_m = ~m; par_na = ~na; par_nb = ~nb;
      settle();
      check("R2");
   endtask

   initial begin
      int unsigned seed;
      cfg_t f;
      seed = $urandom(32'd4242);
      e_cfg = '0;
      e_cfg.na = 3'd3; e_cfg.nb = 3'd3; e_cfg.mint = 6'd21;
      repeat (3) @(negedge clk);
      check("R9 in reset");
      rst_n = 1'b1;
      settle();
      check("R9 after reset");

      // R5 directed frame with a known layout
      f = '{tsel:2'b01, nb:3'd6, na:3'd2, pdiv:3'd4, dsel:2'b11, mint:6'd20, mfrac:12'd2560};
      send_frame(f);
      load_pulse("R5");
      for (int k = 0; k < 4; k++) ser_bit(k[0], "R6 R8", 1'b1);

      // R7 tracking while the transfer line is high
      ser_load = 1'b1;
      settle();
      e_cfg = cfg_t'(e_sr);
      for (int k = 0; k < 3; k++) ser_bit(~k[0], "R7", 1'b1);
      ser_load = 1'b0;
      settle();
      ser_bit(1'b1, "R6", 1'b1);

      // R10 parallel after serial keeps the fraction
      par_op(6'd25, 3'd5, 3'd7);

      // R4 serial ignored in parallel-transparent mode
      par_load_n = 1'b0;
      settle();
      e_cfg.mint = par_m; e_cfg.na = par_na; e_cfg.nb = par_nb;
      for (int k = 0; k < 5; k++) ser_bit(1'b1, "R4", 1'b0);
      load_pulse("R4 R8");
      par_load_n = 1'b1;
      settle();
      load_pulse("R4");

      // R8 reserved codes
      for (int c = 2; c < 4; c++) begin
         f = cfg_t'($urandom);
         f.tsel = c[1:0];
         send_frame(f);
         load_pulse("R5 R8");
         ser_bit(1'b1, "R8", 1'b1);
      end

      // random mix
      for (int r = 0; r < 14; r++) begin
         if ($urandom % 3 == 0) begin
            par_op(6'($urandom), 3'($urandom), 3'($urandom));
         end else begin
            f = cfg_t'($urandom);
            if ($urandom % 4 != 0) f.tsel = {1'b0, f.tsel[0]};
            send_frame(f);
            load_pulse("R5");
            for (int k = 0; k < 3; k++) ser_bit(1'($urandom), "R6 R8", 1'b1);
         end
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule